// File: doc/BRIEF.md
# Ordered ALU Result Writeback Buffer

This block sits between the ALUs of a multi-issue core and the register-file write ports. Each cycle it collects up to `EXEC_LEN` ALU results. Every result carries a wrap-around sequence tag, a destination register index and a data word. The block keeps them in program order and moves the oldest of them into the register file, up to `WRRG_LEN` per cycle.

A result may leave only when it is older than the memory instruction that currently holds authority. That instruction is given by `mem_act` and `mem_tag`. A load can then never be overtaken in the register file by a younger ALU result, and an older ALU result is never held back behind a load that comes after it.

The queue holds `RFBUF_LEN` entries. Write-port outputs are combinational from the queue contents and the present memory tag, so a result drains in the same cycle the boundary admits it. When fewer than `EXEC_LEN` slots are free, the block raises `stall`. During a stall cycle the upstream group is dropped and must be presented again.

The parameters must keep `RFBUF_LEN` at least `WRRG_LEN` and below twice `WRRG_LEN`. This keeps draining faster than memory retirement. The usual setting makes `WRRG_LEN` equal to `EXEC_LEN`.

Top module: `wb_order_buf`

## Requirements
- R1: After reset (asynchronous, active-low `rst_n`) the buffer is empty: `wr_en` is all zero and `stall` is 0, whatever `mem_act` says.
- R2: In a cycle without stall, every lane with its `in_vld` bit set is stored. Lanes are appended behind the existing entries in ascending lane order (lane 0 is the oldest). Lanes whose bit is clear leave no gap.
- R3: The buffer never holds more than `RFBUF_LEN` entries. `stall` is 1 exactly when `RFBUF_LEN` minus the occupancy at the start of the cycle is below `EXEC_LEN`. While `stall` is 1, all input lanes are ignored.
- R4: Draining takes entries from the oldest onward, at most `WRRG_LEN` per cycle. Write port k (slice k of `wr_rd`/`wr_data`) carries the k-th oldest entry. The set bits of `wr_en` always form a run starting at bit 0. Drained entries are removed at the clock edge.
- R5: With `mem_act` = 0, the number of entries written equals the smaller of the occupancy and `WRRG_LEN`.
- R6: With `mem_act` = 1, an entry is written only if its tag is older than `mem_tag`. Tag a is older than tag b when bit `TAG_W`-1 of (a - b) modulo 2^`TAG_W` is 1.
- R7: Draining stops at the first entry that is not older than `mem_tag`. Entries behind it stay even if their own tags are older.
- R8: The age test works across tag wrap-around, for example tag 14 is older than tag 0 with `TAG_W` = 4.
- R9: Write outputs respond in the same cycle to the queue contents and to `mem_act`/`mem_tag`. A result accepted in a cycle can be written no earlier than the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | EXEC_LEN | Per-lane result valid |
| in_tag | input | EXEC_LEN*TAG_W | Per-lane sequence tag |
| in_rd | input | EXEC_LEN*RD_W | Per-lane destination register |
| in_data | input | EXEC_LEN*DATA_W | Per-lane result data |
| mem_act | input | 1 | An active memory instruction exists |
| mem_tag | input | TAG_W | Sequence tag of the active memory instruction |
| wr_en | output | WRRG_LEN | Register-file write enables, one per port |
| wr_rd | output | WRRG_LEN*RD_W | Destination register per write port |
| wr_data | output | WRRG_LEN*DATA_W | Write data per write port |
| stall | output | 1 | Fewer than EXEC_LEN free entries; inputs ignored |

## Verification
The bench builds the block with `EXEC_LEN` = 2, `WRRG_LEN` = 2, `RFBUF_LEN` = 3 and `TAG_W` = 4. A queue of three slots with a two-wide input stalls as soon as two entries are held. This quickly exposes both the stall-drop path and the fully occupied state.

Four-bit tags let a short sequence cross the wrap from 15 to 0. Pushing out-of-order tags on purpose reaches the case where a blocked head hides older entries behind it.

// File: rtl/wb_pkg.sv
package wb_pkg;

  // Wrap-around age test: a precedes b when (a - b) is negative in w bits.
  function automatic logic tag_older(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

  // Number of set bits of mask strictly below position idx.
  function automatic int lane_rank(input logic [31:0] mask, input int idx);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++)
      if (i < idx && mask[i]) r++;
    return r;
  endfunction

endpackage

// File: rtl/wb_lane_pack.sv
module wb_lane_pack import wb_pkg::*; #(
  parameter int EXEC_LEN = 2,
  localparam int POS_W   = $clog2(EXEC_LEN + 1)
) (
  input  logic [EXEC_LEN-1:0]            lane_vld,
  output logic [EXEC_LEN-1:0][POS_W-1:0] lane_pos,
  output logic [POS_W-1:0]               lane_cnt
);

  for (genvar j = 0; j < EXEC_LEN; j++) begin : g_rank
    assign lane_pos[j] = POS_W'(lane_rank(32'(lane_vld), j));
  end

  assign lane_cnt = POS_W'(lane_rank(32'(lane_vld), EXEC_LEN));

endmodule

// File: rtl/wb_drain_sel.sv
module wb_drain_sel import wb_pkg::*; #(
  parameter int WRRG_LEN  = 2,
  parameter int RFBUF_LEN = 3,
  parameter int TAG_W     = 4,
  localparam int CNT_W    = $clog2(RFBUF_LEN + 1),
  localparam int DR_W     = $clog2(WRRG_LEN + 1)
) (
  input  logic [WRRG_LEN-1:0][TAG_W-1:0] head_tag,
  input  logic [CNT_W-1:0]               occ,
  input  logic                           mem_act,
  input  logic [TAG_W-1:0]               mem_tag,
  output logic [WRRG_LEN-1:0]            run,
  output logic [DR_W-1:0]                n_drain
);

  always_comb begin
    logic alive;
    int   n;
    alive = 1'b1;
    n     = 0;
    for (int i = 0; i < WRRG_LEN; i++) begin
      alive  = alive && (i < int'(occ)) &&
               (!mem_act || tag_older(32'(head_tag[i]), 32'(mem_tag), TAG_W));
      run[i] = alive;
      if (alive) n++;
    end
    n_drain = DR_W'(n);
  end

endmodule

// File: rtl/wb_order_buf.sv
module wb_order_buf import wb_pkg::*; #(
  parameter int EXEC_LEN  = 2,
  parameter int WRRG_LEN  = 2,
  parameter int RFBUF_LEN = 3,
  parameter int TAG_W     = 4,
  parameter int RD_W      = 5,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [EXEC_LEN-1:0]          in_vld,
  input  logic [EXEC_LEN*TAG_W-1:0]    in_tag,
  input  logic [EXEC_LEN*RD_W-1:0]     in_rd,
  input  logic [EXEC_LEN*DATA_W-1:0]   in_data,
  input  logic                         mem_act,
  input  logic [TAG_W-1:0]             mem_tag,
  output logic [WRRG_LEN-1:0]          wr_en,
  output logic [WRRG_LEN*RD_W-1:0]     wr_rd,
  output logic [WRRG_LEN*DATA_W-1:0]   wr_data,
  output logic                         stall
);

  localparam int CNT_W = $clog2(RFBUF_LEN + 1);
  localparam int DR_W  = $clog2(WRRG_LEN + 1);
  localparam int POS_W = $clog2(EXEC_LEN + 1);
  localparam int ENT_W = TAG_W + RD_W + DATA_W;

  logic [ENT_W-1:0] ent_q [RFBUF_LEN];
  logic [ENT_W-1:0] ent_d [RFBUF_LEN];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Named internal events for the bound checker.
  logic [WRRG_LEN-1:0][TAG_W-1:0]  head_tag;
  logic [WRRG_LEN-1:0]             drain_run;
  logic [DR_W-1:0]                 n_drain;
  logic [EXEC_LEN-1:0][POS_W-1:0]  lane_pos;
  logic [POS_W-1:0]                lane_cnt;
  logic                            take;
  logic [ENT_W-1:0]                lane_ent [EXEC_LEN];

  for (genvar i = 0; i < WRRG_LEN; i++) begin : g_head
    if (i < RFBUF_LEN) begin : g_real
      assign head_tag[i] = ent_q[i][ENT_W-1 -: TAG_W];
    end else begin : g_none
      assign head_tag[i] = '0;
    end
  end

  for (genvar j = 0; j < EXEC_LEN; j++) begin : g_lane
    assign lane_ent[j] = {in_tag[j*TAG_W +: TAG_W], in_rd[j*RD_W +: RD_W],
                          in_data[j*DATA_W +: DATA_W]};
  end

  wb_lane_pack #(.EXEC_LEN(EXEC_LEN)) u_pack (
    .lane_vld (in_vld),
    .lane_pos (lane_pos),
    .lane_cnt (lane_cnt)
  );

  wb_drain_sel #(.WRRG_LEN(WRRG_LEN), .RFBUF_LEN(RFBUF_LEN), .TAG_W(TAG_W)) u_drain (
    .head_tag (head_tag),
    .occ      (cnt_q),
    .mem_act  (mem_act),
    .mem_tag  (mem_tag),
    .run      (drain_run),
    .n_drain  (n_drain)
  );

  assign stall = (RFBUF_LEN - int'(cnt_q)) < EXEC_LEN;
  assign take  = !stall;
  assign wr_en = drain_run;

  for (genvar i = 0; i < WRRG_LEN; i++) begin : g_port
    if (i < RFBUF_LEN) begin : g_real
      assign wr_rd[i*RD_W +: RD_W]       = drain_run[i] ? ent_q[i][DATA_W +: RD_W] : '0;
      assign wr_data[i*DATA_W +: DATA_W] = drain_run[i] ? ent_q[i][DATA_W-1:0]     : '0;
    end else begin : g_none
      assign wr_rd[i*RD_W +: RD_W]       = '0;
      assign wr_data[i*DATA_W +: DATA_W] = '0;
    end
  end

  // Shift out drained entries, then append accepted lanes behind the survivors.
  always_comb begin
    int keep;
    keep = int'(cnt_q) - int'(n_drain);
    for (int k = 0; k < RFBUF_LEN; k++) begin
      ent_d[k] = ent_q[k];
      for (int s = 0; s < RFBUF_LEN; s++)
        if (s == k + int'(n_drain)) ent_d[k] = ent_q[s];
    end
    if (take) begin
      for (int j = 0; j < EXEC_LEN; j++)
        for (int k = 0; k < RFBUF_LEN; k++)
          if (in_vld[j] && (k == keep + int'(lane_pos[j]))) ent_d[k] = lane_ent[j];
      cnt_d = CNT_W'(keep + int'(lane_cnt));
    end else begin
      cnt_d = CNT_W'(keep);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < RFBUF_LEN; k++) ent_q[k] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int k = 0; k < RFBUF_LEN; k++) ent_q[k] <= ent_d[k];
    end
  end

endmodule

// File: rtl/wb_order_buf_chk.sv
module wb_order_buf_chk import wb_pkg::*; #(
  parameter int EXEC_LEN  = 2,
  parameter int WRRG_LEN  = 2,
  parameter int RFBUF_LEN = 3,
  parameter int TAG_W     = 4,
  localparam int CNT_W    = $clog2(RFBUF_LEN + 1)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [CNT_W-1:0]               cnt,
  input logic [WRRG_LEN-1:0]            wr_en,
  input logic [WRRG_LEN-1:0][TAG_W-1:0] head_tag,
  input logic                           mem_act,
  input logic [TAG_W-1:0]               mem_tag,
  input logic                           stall
);

  localparam int MINW = (RFBUF_LEN < WRRG_LEN) ? RFBUF_LEN : WRRG_LEN;

  // R3: occupancy bound
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= RFBUF_LEN);

  // R3: a stalled cycle cannot grow the queue
  p_stall_no_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> cnt <= $past(cnt));

  // R4: enables form a run from port 0
  p_prefix_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en + 1'b1) & wr_en) == '0);

  // R5: free drain without an active memory instruction
  p_free_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_act |-> $countones(wr_en) == ((int'(cnt) < MINW) ? int'(cnt) : MINW));

  // R6: every written entry is older than the memory boundary
  for (genvar i = 0; i < WRRG_LEN; i++) begin : g_old
    p_older_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_act && wr_en[i]) |-> tag_older(32'(head_tag[i]), 32'(mem_tag), TAG_W));
  end

  // R7: a blocked head blocks everything
  p_blocked_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_act && cnt != '0 && !tag_older(32'(head_tag[0]), 32'(mem_tag), TAG_W))
      |-> wr_en == '0);

endmodule

bind wb_order_buf wb_order_buf_chk #(
  .EXEC_LEN(EXEC_LEN), .WRRG_LEN(WRRG_LEN), .RFBUF_LEN(RFBUF_LEN), .TAG_W(TAG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (cnt_q),
  .wr_en    (wr_en),
  .head_tag (head_tag),
  .mem_act  (mem_act),
  .mem_tag  (mem_tag),
  .stall    (stall)
);

// File: tb/wb_order_buf_tb.sv
`timescale 1ns/1ps
module wb_order_buf_tb;

  localparam int EL = 2, WL = 2, BL = 3, TW = 4, RW = 5, DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [EL-1:0]   in_vld = '0;
  logic [EL*TW-1:0] in_tag = '0;
  logic [EL*RW-1:0] in_rd = '0;
  logic [EL*DW-1:0] in_data = '0;
  logic            mem_act = 1'b0;
  logic [TW-1:0]   mem_tag = '0;
  logic [WL-1:0]   wr_en;
  logic [WL*RW-1:0] wr_rd;
  logic [WL*DW-1:0] wr_data;
  logic            stall;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wb_order_buf #(.EXEC_LEN(EL), .WRRG_LEN(WL), .RFBUF_LEN(BL), .TAG_W(TW),
                 .RD_W(RW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_tag(in_tag), .in_rd(in_rd),
    .in_data(in_data), .mem_act(mem_act), .mem_tag(mem_tag), .wr_en(wr_en),
    .wr_rd(wr_rd), .wr_data(wr_data), .stall(stall));

  typedef struct packed {
    logic [7:0] req;
    logic [1:0] vld;
    logic [3:0] t0, t1;
    logic       ma;
    logic [3:0] mt;
    logic [1:0] en;
    logic [3:0] e0, e1;
    logic       st;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{8'd2, 2'b11, 4'd0,  4'd1,  1'b0, 4'd0,  2'b00, 4'd0,  4'd0,  1'b0}, // R2 push 0,1
    '{8'd3, 2'b11, 4'd2,  4'd3,  1'b1, 4'd1,  2'b01, 4'd0,  4'd0,  1'b1}, // R3 drop, R6 drain 0
    '{8'd6, 2'b01, 4'd2,  4'd0,  1'b1, 4'd1,  2'b00, 4'd0,  4'd0,  1'b0}, // R6 head 1 blocked
    '{8'd6, 2'b00, 4'd0,  4'd0,  1'b1, 4'd3,  2'b11, 4'd1,  4'd2,  1'b1}, // R6 both older
    '{8'd2, 2'b10, 4'd0,  4'd3,  1'b0, 4'd0,  2'b00, 4'd0,  4'd0,  1'b0}, // R2 lane1 only
    '{8'd9, 2'b11, 4'd4,  4'd5,  1'b0, 4'd0,  2'b01, 4'd3,  4'd0,  1'b0}, // R9 drain 3 only
    '{8'd6, 2'b00, 4'd0,  4'd0,  1'b1, 4'd5,  2'b01, 4'd4,  4'd0,  1'b1}, // R6
    '{8'd9, 2'b11, 4'd6,  4'd7,  1'b1, 4'd5,  2'b00, 4'd0,  4'd0,  1'b0}, // R9 fill to 3
    '{8'd7, 2'b00, 4'd0,  4'd0,  1'b1, 4'd6,  2'b01, 4'd5,  4'd0,  1'b1}, // R7 stop at 6
    '{8'd5, 2'b00, 4'd0,  4'd0,  1'b0, 4'd0,  2'b11, 4'd6,  4'd7,  1'b1}, // R5 free drain
    '{8'd8, 2'b11, 4'd14, 4'd15, 1'b0, 4'd0,  2'b00, 4'd0,  4'd0,  1'b0}, // R8 push 14,15
    '{8'd8, 2'b11, 4'd0,  4'd1,  1'b1, 4'd0,  2'b11, 4'd14, 4'd15, 1'b1}, // R8 older across wrap
    '{8'd8, 2'b11, 4'd0,  4'd1,  1'b1, 4'd15, 2'b00, 4'd0,  4'd0,  1'b0}, // R8 push 0,1
    '{8'd8, 2'b00, 4'd0,  4'd0,  1'b1, 4'd1,  2'b01, 4'd0,  4'd0,  1'b1}, // R8 0 older than 1
    '{8'd5, 2'b11, 4'd2,  4'd3,  1'b0, 4'd0,  2'b01, 4'd1,  4'd0,  1'b0}, // R5 count 1
    '{8'd4, 2'b00, 4'd0,  4'd0,  1'b0, 4'd0,  2'b11, 4'd2,  4'd3,  1'b1}, // R4 order
    '{8'd2, 2'b11, 4'd8,  4'd2,  1'b0, 4'd0,  2'b00, 4'd0,  4'd0,  1'b0}, // R2 push 8,2
    '{8'd7, 2'b00, 4'd0,  4'd0,  1'b1, 4'd5,  2'b00, 4'd0,  4'd0,  1'b1}, // R7 hidden older 2
    '{8'd7, 2'b00, 4'd0,  4'd0,  1'b1, 4'd9,  2'b11, 4'd8,  4'd2,  1'b1}, // R7 released
    '{8'd2, 2'b01, 4'd10, 4'd0,  1'b0, 4'd0,  2'b00, 4'd0,  4'd0,  1'b0}, // R2
    '{8'd3, 2'b11, 4'd11, 4'd12, 1'b1, 4'd10, 2'b00, 4'd0,  4'd0,  1'b0}, // R3 fill full
    '{8'd3, 2'b11, 4'd13, 4'd14, 1'b1, 4'd10, 2'b00, 4'd0,  4'd0,  1'b1}, // R3 full, dropped
    '{8'd4, 2'b00, 4'd0,  4'd0,  1'b0, 4'd0,  2'b11, 4'd10, 4'd11, 1'b1}, // R4 cap WRRG_LEN
    '{8'd4, 2'b00, 4'd0,  4'd0,  1'b0, 4'd0,  2'b01, 4'd12, 4'd0,  1'b0}, // R4
    '{8'd3, 2'b00, 4'd0,  4'd0,  1'b0, 4'd0,  2'b00, 4'd0,  4'd0,  1'b0}  // R3 empty again
  };

  function automatic logic [RW-1:0] rd_of(input logic [3:0] t);
    return RW'(t) + RW'(1);
  endfunction
  function automatic logic [DW-1:0] data_of(input logic [3:0] t);
    return {8'h5A, 4'h0, t};
  endfunction

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] v, input logic [3:0] a, input logic [3:0] b,
                       input logic ma, input logic [3:0] mt);
    in_vld  = v;
    in_tag  = {b, a};
    in_rd   = {rd_of(b), rd_of(a)};
    in_data = {data_of(b), data_of(a)};
    mem_act = ma;
    mem_tag = mt;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with an active-looking drain request
    drive(2'b00, 0, 0, 1'b0, 0);
    #12;
    check(1, "wr_en in reset", 32'(wr_en), 0);
    check(1, "stall in reset", 32'(stall), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      drive(TBL[n].vld, TBL[n].t0, TBL[n].t1, TBL[n].ma, TBL[n].mt);
      #1;
      check(int'(TBL[n].req), $sformatf("v%0d wr_en", n), 32'(wr_en), 32'(TBL[n].en));
      check(int'(TBL[n].req), $sformatf("v%0d stall", n), 32'(stall), 32'(TBL[n].st));
      if (TBL[n].en[0]) begin
        check(4, $sformatf("v%0d port0 rd", n), 32'(wr_rd[0 +: RW]), 32'(rd_of(TBL[n].e0)));
        check(4, $sformatf("v%0d port0 data", n), 32'(wr_data[0 +: DW]), 32'(data_of(TBL[n].e0)));
      end
      if (TBL[n].en[1]) begin
        check(4, $sformatf("v%0d port1 rd", n), 32'(wr_rd[RW +: RW]), 32'(rd_of(TBL[n].e1)));
        check(4, $sformatf("v%0d port1 data", n), 32'(wr_data[DW +: DW]), 32'(data_of(TBL[n].e1)));
      end
      @(negedge clk);
    end

    // R1: reset in the middle of a run empties the queue
    drive(2'b11, 4'd1, 4'd2, 1'b1, 4'd0);
    @(negedge clk);
    drive(2'b00, 0, 0, 1'b1, 4'd0);
    #1;
    check(9, "held behind mem tag", 32'(wr_en), 0);
    check(3, "stall with two held", 32'(stall), 1);
    rst_n = 1'b0;
    #1;
    check(1, "stall during reset", 32'(stall), 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(2'b00, 0, 0, 1'b0, 0);
    #1;
    check(1, "no drain after reset", 32'(wr_en), 0);
    check(1, "stall after reset", 32'(stall), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule